// File: doc/BRIEF.md
# Shared-Line Key, Switch, Sensor and Display Scanner

This block drives one set of active-low scan lines that serve four things at once. It services a key matrix, an eight-position mode switch, four single-bit sensors that share one return line, and the digit strobes of a multiplexed seven-segment display. The line to drive comes from a 4-bit scan code. The code is decoded by banks of 3-to-8 decoders, and only the lowest `SLOTS` outputs are brought out. Each slot has four phases in this order. First the segment byte for that digit is presented. Then its scan line is pulled low. After a settle delay the return inputs are sampled. Finally a blanking gap follows, with every line released and the segments off.

Software or a host controller writes one segment byte per digit through a chip-select strobe. The block then refreshes the display without further help. Return readings go through a per-bit filter that needs two matching full frames. From the filtered state the block publishes three results. Newly pressed keys come out one per frame as a code. The mode switch position and the four sensor flags are held as levels. Character fonts and the meaning of each key are handled elsewhere.

Top module: `keyscan_mux`

## Requirements
- R1: At most one scan line is low at any time. Lines are activated in strictly rising index order 0, 1, ..., SLOTS-1, then wrap to 0. The line for code k is the active-low output k of the decoder bank selected by code bit 3.
- R2: A byte written with `seg_cs` high to `seg_addr` = d is shown on `seg_out` (bit 0 = segment a up to bit 7 = dp) whenever line d is low. It is already present in the cycle before line d goes low.
- R3: Between two consecutive active lines, all lines stay high for exactly GAP_CYC+1 cycles. `seg_out` is zero for the first GAP_CYC of those cycles.
- R4: A key reads as pressed when return input `key_ret_n[c]` is low while line s is low. It is accepted only once it has read pressed at the sample points of two consecutive full frames. On acceptance `key_valid` pulses for exactly one cycle with `key_code` = {s[3:0], c[2:0]}.
- R5: A key reading that appears in only one frame never produces a `key_valid` pulse.
- R6: At most one `key_valid` pulse occurs per frame. When several keys are accepted together, they are reported in ascending code order, one per frame, with pulses exactly one frame apart.
- R7: A key that stays pressed is reported once. After it has been accepted as released, a new press is reported again.
- R8: The mode switch is read on lines 0 to MODE_SLOTS-1 through `mode_ret_n`, where low means connected. After two matching frames, `mode_ok` is high and `mode_pos` equals the line index (0 = service, 2 = unused position, 7 = last position). With no connection, `mode_ok` drops to low.
- R9: The shared return `aux_ret_n`, when low, means detected. It is read on line 1 for the feed key, line 3 for head up, line 4 for paper end and line 9 for the serial CI detect. Each output is active high and filtered over two frames, and each is independent of the others.
- R10: While reset is asserted, all scan lines are high, `seg_out` is zero and `key_valid`, `mode_ok` and all sensor flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| seg_cs | input | 1 | Chip-select strobe that latches `seg_data` into a digit |
| seg_addr | input | 4 | Digit index for the write |
| seg_data | input | SEG_W | Segment byte, bit 0 = a ... bit 7 = dp |
| key_ret_n | input | RET_W | Key matrix return lines, active low |
| mode_ret_n | input | 1 | Mode switch return line, active low |
| aux_ret_n | input | 1 | Shared sensor return line, active low |
| scan_n | output | SLOTS | Active-low scan lines / digit strobes |
| seg_out | output | SEG_W | Segment drive for the active digit |
| key_valid | output | 1 | One-cycle pulse for a newly accepted key |
| key_code | output | 4+clog2(RET_W) | {scan line, return index} of that key |
| mode_ok | output | 1 | A mode position is connected |
| mode_pos | output | clog2(MODE_SLOTS) | Mode switch position |
| feed_key | output | 1 | Feed key pressed |
| head_up | output | 1 | Print head lifted |
| paper_end | output | 1 | Paper end reached |
| ci_det | output | 1 | Serial CI signal present |

## Verification
The bench keeps the default ten lines, six returns and eight mode positions. It shortens the settle time to 2 cycles and the gap to 2 cycles, which gives a 6-cycle slot and a 60-cycle frame. With frames that short, the bench can see in a few hundred cycles the cases that depend on frame order. These are a press seen in a single frame, two keys accepted together and reported a frame apart, release then re-press, and a sensor still low after its first frame. The key matrix, switch and sensors are modelled from the live scan lines. Because of that, line order, digit timing and blanking are checked against the same outputs that drive the returns.

// File: rtl/keyscan_pkg.sv
package keyscan_pkg;
  localparam int CODE_W = 4;
  localparam int BANK_LINES = 8;

  localparam int FEED_LINE = 1;
  localparam int HEADUP_LINE = 3;
  localparam int PAPEREND_LINE = 4;
  localparam int CI_LINE = 9;
  localparam int AUX_N = 4;

  typedef enum logic [1:0] {
    PH_LOAD,
    PH_SETTLE,
    PH_SAMPLE,
    PH_GAP
  } phase_t;
endpackage

// File: rtl/keyscan_seq.sv
module keyscan_seq
  import keyscan_pkg::*;
#(
  parameter int SLOTS      = 10,
  parameter int SETTLE_CYC = 4,
  parameter int GAP_CYC    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [CODE_W-1:0] slot_q,
  output logic [CODE_W-1:0] slot_d,
  output logic              drive_d,
  output logic              show_d,
  output logic              sample,
  output logic              last_sample
);
  localparam int CNT_MAX = (SETTLE_CYC > GAP_CYC) ? SETTLE_CYC : GAP_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  phase_t             phase_q, phase_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    slot_d  = slot_q;
    case (phase_q)
      PH_LOAD: begin
        phase_d = PH_SETTLE;
        cnt_d   = '0;
      end
      PH_SETTLE: begin
        if (cnt_q == CNT_W'(SETTLE_CYC - 1)) begin
          phase_d = PH_SAMPLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_SAMPLE: begin
        phase_d = PH_GAP;
        cnt_d   = '0;
      end
      default: begin
        if (cnt_q == CNT_W'(GAP_CYC - 1)) begin
          phase_d = PH_LOAD;
          cnt_d   = '0;
          slot_d  = (slot_q == CODE_W'(SLOTS - 1)) ? '0 : slot_q + 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_LOAD;
      cnt_q   <= '0;
      slot_q  <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      slot_q  <= slot_d;
    end
  end

  assign drive_d     = (phase_d == PH_SETTLE) || (phase_d == PH_SAMPLE);
  assign show_d      = (phase_d != PH_GAP);
  assign sample      = (phase_q == PH_SAMPLE);
  assign last_sample = sample && (slot_q == CODE_W'(SLOTS - 1));
endmodule

// File: rtl/keyscan_decode.sv
module keyscan_decode
  import keyscan_pkg::*;
#(
  parameter int SLOTS = 10
) (
  input  logic [CODE_W-1:0] code,
  input  logic              en,
  output logic [SLOTS-1:0]  line_n
);
  localparam int BANKS = (SLOTS + BANK_LINES - 1) / BANK_LINES;

  for (genvar b = 0; b < BANKS; b++) begin : bank_g
    logic bank_en;
    assign bank_en = en && (code[CODE_W-1] == 1'(b));
    for (genvar k = 0; k < BANK_LINES; k++) begin : out_g
      if (b * BANK_LINES + k < SLOTS) begin : used_g
        assign line_n[b*BANK_LINES+k] = !(bank_en && (code[2:0] == 3'(k)));
      end
    end
  end
endmodule

// File: rtl/keyscan_segs.sv
module keyscan_segs
  import keyscan_pkg::*;
#(
  parameter int SLOTS = 10,
  parameter int SEG_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [CODE_W-1:0] waddr,
  input  logic [SEG_W-1:0]  wdata,
  input  logic              show_d,
  input  logic [CODE_W-1:0] slot_d,
  output logic [SEG_W-1:0]  seg_q
);
  logic [SEG_W-1:0] digit_q [SLOTS];
  logic [SEG_W-1:0] seg_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int d = 0; d < SLOTS; d++) digit_q[d] <= '0;
    end else if (wr) begin
      for (int d = 0; d < SLOTS; d++) begin
        if (waddr == CODE_W'(d)) digit_q[d] <= wdata;
      end
    end
  end

  always_comb begin
    seg_d = '0;
    if (show_d) begin
      for (int d = 0; d < SLOTS; d++) begin
        if (slot_d == CODE_W'(d)) seg_d = digit_q[d];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seg_q <= '0;
    else        seg_q <= seg_d;
  end
endmodule

// File: rtl/keyscan_ret.sv
module keyscan_ret
  import keyscan_pkg::*;
#(
  parameter int SLOTS      = 10,
  parameter int RET_W      = 6,
  parameter int MODE_SLOTS = 8,
  localparam int COL_W     = $clog2(RET_W),
  localparam int KC_W      = CODE_W + COL_W,
  localparam int MP_W      = $clog2(MODE_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample,
  input  logic              last_sample,
  input  logic [CODE_W-1:0] slot_q,
  input  logic [RET_W-1:0]  key_ret_n,
  input  logic              mode_ret_n,
  input  logic              aux_ret_n,
  output logic              key_valid,
  output logic [KC_W-1:0]   key_code,
  output logic              mode_ok,
  output logic [MP_W-1:0]   mode_pos,
  output logic              feed_key,
  output logic              head_up,
  output logic              paper_end,
  output logic              ci_det
);
  localparam int KEYS  = SLOTS * RET_W;
  localparam int MODEB = KEYS;
  localparam int AUXB  = KEYS + MODE_SLOTS;
  localparam int TOT   = AUXB + AUX_N;

  logic [TOT-1:0]  raw_q, raw_d, prev_q, prev_d, stab_q, stab_d, diff;
  logic [KEYS-1:0] rep_q, rep_d, key_stab, rep_keep, cand, pick_oh;
  logic [KC_W-1:0] pick_code, kc_d;
  logic            found, done_q, kv_d;

  // capture of the current frame's readings at each sample point
  always_comb begin
    raw_d = raw_q;
    if (sample) begin
      for (int s = 0; s < SLOTS; s++) begin
        if (slot_q == CODE_W'(s)) begin
          for (int c = 0; c < RET_W; c++) raw_d[s*RET_W+c] = !key_ret_n[c];
          if (s < MODE_SLOTS)    raw_d[MODEB+s]  = !mode_ret_n;
          if (s == FEED_LINE)    raw_d[AUXB+0]   = !aux_ret_n;
          if (s == HEADUP_LINE)  raw_d[AUXB+1]   = !aux_ret_n;
          if (s == PAPEREND_LINE) raw_d[AUXB+2]  = !aux_ret_n;
          if (s == CI_LINE)      raw_d[AUXB+3]   = !aux_ret_n;
        end
      end
    end
  end

  // per-bit two-frame filter, evaluated once per frame
  assign diff   = raw_q ^ prev_q;
  assign stab_d = done_q ? ((raw_q & ~diff) | (stab_q & diff)) : stab_q;
  assign prev_d = done_q ? raw_q : prev_q;

  // newly accepted keys, lowest code first, one per frame
  assign key_stab = stab_d[KEYS-1:0];
  assign rep_keep = rep_q & key_stab;
  assign cand     = key_stab & ~rep_keep;

  always_comb begin
    found     = 1'b0;
    pick_code = '0;
    pick_oh   = '0;
    for (int i = KEYS - 1; i >= 0; i--) begin
      if (cand[i]) begin
        found     = 1'b1;
        pick_code = {CODE_W'(i / RET_W), COL_W'(i % RET_W)};
        pick_oh   = '0;
        pick_oh[i] = 1'b1;
      end
    end
  end

  always_comb begin
    rep_d = rep_q;
    kv_d  = 1'b0;
    kc_d  = key_code;
    if (done_q) begin
      rep_d = rep_keep | pick_oh;
      kv_d  = found;
      if (found) kc_d = pick_code;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q     <= '0;
      prev_q    <= '0;
      stab_q    <= '0;
      rep_q     <= '0;
      done_q    <= 1'b0;
      key_valid <= 1'b0;
      key_code  <= '0;
    end else begin
      raw_q     <= raw_d;
      prev_q    <= prev_d;
      stab_q    <= stab_d;
      rep_q     <= rep_d;
      done_q    <= last_sample;
      key_valid <= kv_d;
      key_code  <= kc_d;
    end
  end

  always_comb begin
    mode_pos = '0;
    for (int m = MODE_SLOTS - 1; m >= 0; m--) begin
      if (stab_q[MODEB+m]) mode_pos = MP_W'(m);
    end
  end

  assign mode_ok   = |stab_q[MODEB +: MODE_SLOTS];
  assign feed_key  = stab_q[AUXB+0];
  assign head_up   = stab_q[AUXB+1];
  assign paper_end = stab_q[AUXB+2];
  assign ci_det    = stab_q[AUXB+3];
endmodule

// File: rtl/keyscan_mux.sv
module keyscan_mux
  import keyscan_pkg::*;
#(
  parameter int SLOTS      = 10,
  parameter int RET_W      = 6,
  parameter int MODE_SLOTS = 8,
  parameter int SETTLE_CYC = 4,
  parameter int GAP_CYC    = 3,
  parameter int SEG_W      = 8
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 seg_cs,
  input  logic [keyscan_pkg::CODE_W-1:0]       seg_addr,
  input  logic [SEG_W-1:0]                     seg_data,
  input  logic [RET_W-1:0]                     key_ret_n,
  input  logic                                 mode_ret_n,
  input  logic                                 aux_ret_n,
  output logic [SLOTS-1:0]                     scan_n,
  output logic [SEG_W-1:0]                     seg_out,
  output logic                                 key_valid,
  output logic [keyscan_pkg::CODE_W+$clog2(RET_W)-1:0] key_code,
  output logic                                 mode_ok,
  output logic [$clog2(MODE_SLOTS)-1:0]        mode_pos,
  output logic                                 feed_key,
  output logic                                 head_up,
  output logic                                 paper_end,
  output logic                                 ci_det
);
  logic [1:0]        rst_pipe;
  logic              rst_core_n;
  logic [CODE_W-1:0] slot_q, slot_d;
  logic              drive_d, show_d, sample, last_sample;
  logic [SLOTS-1:0]  line_d_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  keyscan_seq #(
    .SLOTS(SLOTS), .SETTLE_CYC(SETTLE_CYC), .GAP_CYC(GAP_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_core_n), .slot_q(slot_q), .slot_d(slot_d),
    .drive_d(drive_d), .show_d(show_d), .sample(sample),
    .last_sample(last_sample)
  );

  keyscan_decode #(.SLOTS(SLOTS)) u_dec (
    .code(slot_d), .en(drive_d), .line_n(line_d_n)
  );

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) scan_n <= '1;
    else             scan_n <= line_d_n;
  end

  keyscan_segs #(.SLOTS(SLOTS), .SEG_W(SEG_W)) u_segs (
    .clk(clk), .rst_n(rst_core_n), .wr(seg_cs), .waddr(seg_addr),
    .wdata(seg_data), .show_d(show_d), .slot_d(slot_d), .seg_q(seg_out)
  );

  keyscan_ret #(
    .SLOTS(SLOTS), .RET_W(RET_W), .MODE_SLOTS(MODE_SLOTS)
  ) u_ret (
    .clk(clk), .rst_n(rst_core_n), .sample(sample),
    .last_sample(last_sample), .slot_q(slot_q), .key_ret_n(key_ret_n),
    .mode_ret_n(mode_ret_n), .aux_ret_n(aux_ret_n),
    .key_valid(key_valid), .key_code(key_code), .mode_ok(mode_ok),
    .mode_pos(mode_pos), .feed_key(feed_key), .head_up(head_up),
    .paper_end(paper_end), .ci_det(ci_det)
  );
endmodule

// File: rtl/keyscan_mux_chk.sv
module keyscan_mux_chk #(
  parameter int SLOTS = 10,
  parameter int SEG_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [SLOTS-1:0] scan_n,
  input logic [SEG_W-1:0] seg_out,
  input logic             key_valid
);
  logic       all_hi, hi_q, seen;
  logic [3:0] cur_idx, last_idx, exp_idx;

  assign all_hi = &scan_n;

  always_comb begin
    cur_idx = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (!scan_n[i]) cur_idx = 4'(i);
    end
  end

  assign exp_idx = (last_idx == 4'(SLOTS - 1)) ? 4'd0 : last_idx + 4'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q     <= 1'b1;
      seen     <= 1'b0;
      last_idx <= '0;
    end else begin
      hi_q <= all_hi;
      if (!all_hi && hi_q) begin
        seen     <= 1'b1;
        last_idx <= cur_idx;
      end
    end
  end

  p_one_line_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~scan_n) <= 1);

  p_order_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!all_hi && hi_q && seen) |-> (cur_idx == exp_idx));

  p_seg_lead_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!all_hi && hi_q) |-> $stable(seg_out));

  p_blank_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (all_hi && !hi_q) |-> (seg_out == '0));

  p_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |=> !key_valid);
endmodule

bind keyscan_mux keyscan_mux_chk #(.SLOTS(SLOTS), .SEG_W(SEG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scan_n(scan_n), .seg_out(seg_out),
  .key_valid(key_valid)
);

// File: tb/keyscan_mux_bench.sv
module keyscan_mux_bench;
  localparam int SLOTS = 10, RET_W = 6, MODE_SLOTS = 8;
  localparam int SETTLE = 2, GAP = 2;
  localparam int FRAME = SLOTS * (SETTLE + GAP + 2);

  logic clk = 1'b0;
  logic rst_n;
  logic seg_cs;
  logic [3:0] seg_addr;
  logic [7:0] seg_data;
  logic [RET_W-1:0] key_ret_n;
  logic mode_ret_n, aux_ret_n;
  logic [SLOTS-1:0] scan_n;
  logic [7:0] seg_out;
  logic key_valid, mode_ok, feed_key, head_up, paper_end, ci_det;
  logic [6:0] key_code;
  logic [2:0] mode_pos;

  logic [SLOTS*RET_W-1:0] keys_dn;
  logic [MODE_SLOTS-1:0] mode_on;
  logic a_feed, a_head, a_pend, a_ci;
  logic [7:0] digit_m [SLOTS];

  int checks = 0, fails = 0, cyc = 0;
  int pn = 0;
  int pulse_code [32];
  int pulse_t [32];
  bit mon_on = 0, mon_prev = 0;
  int mon_last = 0, hi_run = 0, mon_act = 0;
  int err_seg = 0, err_gap = 0, err_ord = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  keyscan_mux #(
    .SLOTS(SLOTS), .RET_W(RET_W), .MODE_SLOTS(MODE_SLOTS),
    .SETTLE_CYC(SETTLE), .GAP_CYC(GAP), .SEG_W(8)
  ) u_keyscan_mux (
    .clk(clk), .rst_n(rst_n), .seg_cs(seg_cs), .seg_addr(seg_addr),
    .seg_data(seg_data), .key_ret_n(key_ret_n), .mode_ret_n(mode_ret_n),
    .aux_ret_n(aux_ret_n), .scan_n(scan_n), .seg_out(seg_out),
    .key_valid(key_valid), .key_code(key_code), .mode_ok(mode_ok),
    .mode_pos(mode_pos), .feed_key(feed_key), .head_up(head_up),
    .paper_end(paper_end), .ci_det(ci_det)
  );

  // models of the matrix, switch and sensors, driven from the live lines
  always_comb begin
    key_ret_n  = '1;
    mode_ret_n = 1'b1;
    for (int s = 0; s < SLOTS; s++)
      for (int c = 0; c < RET_W; c++)
        if (keys_dn[s*RET_W+c] && !scan_n[s]) key_ret_n[c] = 1'b0;
    for (int s = 0; s < MODE_SLOTS; s++)
      if (mode_on[s] && !scan_n[s]) mode_ret_n = 1'b0;
    aux_ret_n = !((a_feed && !scan_n[1]) || (a_head && !scan_n[3]) ||
                  (a_pend && !scan_n[4]) || (a_ci && !scan_n[9]));
  end

  // pulse logger and line/segment monitor
  always @(negedge clk) begin
    if (key_valid && pn < 32) begin
      pulse_code[pn] = int'(key_code);
      pulse_t[pn] = cyc;
      pn = pn + 1;
    end
    if (mon_on) begin
      if (!(&scan_n)) begin
        int idx;
        idx = 0;
        for (int i = SLOTS - 1; i >= 0; i--) if (!scan_n[i]) idx = i;
        if ($countones(~scan_n) != 1) err_ord++;
        if (seg_out != digit_m[idx]) err_seg++;
        if (hi_run > 0) begin
          if (mon_prev) begin
            if (idx != (mon_last + 1) % SLOTS) err_ord++;
            if (hi_run != GAP + 1) err_gap++;
          end
          mon_prev = 1;
          mon_last = idx;
          mon_act++;
        end
        hi_run = 0;
      end else begin
        hi_run++;
        if (mon_prev && hi_run <= GAP && seg_out != 8'h00) err_gap++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sync_frame();
    while (scan_n[9] !== 1'b0) @(negedge clk);
    while (scan_n[9] !== 1'b1) @(negedge clk);
  endtask

  task automatic mon_window(input int n);
    err_seg = 0; err_gap = 0; err_ord = 0; mon_act = 0;
    mon_prev = 0; hi_run = 0;
    mon_on = 1;
    wait_cyc(n);
    mon_on = 0;
  endtask

  task automatic t_reset();
    wait_cyc(3);
    chk(scan_n == '1, "R10 lines high", int'(scan_n), 1023);
    chk(seg_out == 8'h00, "R10 segments off", int'(seg_out), 0);
    chk({key_valid, mode_ok, feed_key, head_up, paper_end, ci_det} == 6'b0,
        "R10 flags low",
        int'({key_valid, mode_ok, feed_key, head_up, paper_end, ci_det}), 0);
    rst_n = 1'b1;
    wait_cyc(5);
  endtask

  task automatic t_scan_order();
    mon_window(2 * FRAME + 10);
    chk(err_ord == 0, "R1 line order", err_ord, 0);
    chk(mon_act >= 2 * SLOTS, "R1 activations", mon_act, 2 * SLOTS);
  endtask

  task automatic t_segments();
    for (int d = 0; d < SLOTS; d++) begin
      seg_cs = 1'b1;
      seg_addr = 4'(d);
      seg_data = 8'((d * 29 + 3) | 1);
      digit_m[d] = 8'((d * 29 + 3) | 1);
      @(negedge clk);
    end
    seg_cs = 1'b0;
    wait_cyc(FRAME);
    mon_window(2 * FRAME + 10);
    chk(err_seg == 0, "R2 digit data", err_seg, 0);
    chk(err_gap == 0, "R3 gap and blanking", err_gap, 0);
  endtask

  task automatic t_single_key();
    int p0;
    sync_frame();
    p0 = pn;
    keys_dn[5*RET_W+3] = 1'b1;
    wait_cyc(FRAME + 10);
    chk(pn == p0, "R4 not after one frame", pn - p0, 0);
    wait_cyc(2 * FRAME);
    chk(pn == p0 + 1, "R4 accepted once", pn - p0, 1);
    chk(pulse_code[p0] == 43, "R4 key code", pulse_code[p0], 43);
  endtask

  task automatic t_hold_repress();
    int p0;
    p0 = pn;
    wait_cyc(4 * FRAME);
    chk(pn == p0, "R7 held key not repeated", pn - p0, 0);
    keys_dn[5*RET_W+3] = 1'b0;
    wait_cyc(4 * FRAME);
    chk(pn == p0, "R7 release silent", pn - p0, 0);
    sync_frame();
    keys_dn[5*RET_W+3] = 1'b1;
    wait_cyc(3 * FRAME);
    chk(pn == p0 + 1 && pulse_code[p0] == 43, "R7 re-press reported", pn - p0, 1);
    keys_dn = '0;
    wait_cyc(4 * FRAME);
  endtask

  task automatic t_glitch();
    int p0;
    sync_frame();
    p0 = pn;
    wait_cyc(30);
    keys_dn[7*RET_W+0] = 1'b1;
    wait_cyc(25);
    keys_dn[7*RET_W+0] = 1'b0;
    wait_cyc(4 * FRAME);
    chk(pn == p0, "R5 one-frame reading ignored", pn - p0, 0);
  endtask

  task automatic t_multi();
    int p0;
    sync_frame();
    p0 = pn;
    keys_dn[2*RET_W+1] = 1'b1;
    keys_dn[0*RET_W+5] = 1'b1;
    wait_cyc(4 * FRAME);
    chk(pn == p0 + 2, "R6 two reports", pn - p0, 2);
    chk(pulse_code[p0] == 5, "R6 lower code first", pulse_code[p0], 5);
    chk(pulse_code[p0+1] == 17, "R6 second code", pulse_code[p0+1], 17);
    chk(pulse_t[p0+1] - pulse_t[p0] == FRAME, "R6 one frame apart",
        pulse_t[p0+1] - pulse_t[p0], FRAME);
    keys_dn = '0;
    wait_cyc(4 * FRAME);
  endtask

  task automatic t_mode();
    int pos [3] = '{4, 2, 7};
    for (int k = 0; k < 3; k++) begin
      sync_frame();
      mode_on = 8'(1 << pos[k]);
      wait_cyc(3 * FRAME);
      chk(mode_ok == 1'b1, "R8 mode connected", int'(mode_ok), 1);
      chk(int'(mode_pos) == pos[k], "R8 mode position", int'(mode_pos), pos[k]);
    end
    mode_on = '0;
    wait_cyc(3 * FRAME);
    chk(mode_ok == 1'b0, "R8 no position", int'(mode_ok), 0);
  endtask

  task automatic t_aux();
    sync_frame();
    a_head = 1'b1;
    wait_cyc(FRAME + 10);
    chk(head_up == 1'b0, "R9 head up filtered", int'(head_up), 0);
    wait_cyc(2 * FRAME);
    chk({feed_key, head_up, paper_end, ci_det} == 4'b0100, "R9 head up only",
        int'({feed_key, head_up, paper_end, ci_det}), 4);
    a_head = 1'b0;
    a_pend = 1'b1;
    wait_cyc(3 * FRAME);
    chk({feed_key, head_up, paper_end, ci_det} == 4'b0010, "R9 paper end only",
        int'({feed_key, head_up, paper_end, ci_det}), 2);
    a_feed = 1'b1; a_head = 1'b1; a_ci = 1'b1;
    wait_cyc(3 * FRAME);
    chk({feed_key, head_up, paper_end, ci_det} == 4'b1111, "R9 all detected",
        int'({feed_key, head_up, paper_end, ci_det}), 15);
    a_feed = 1'b0; a_head = 1'b0; a_pend = 1'b0; a_ci = 1'b0;
    wait_cyc(3 * FRAME);
    chk({feed_key, head_up, paper_end, ci_det} == 4'b0000, "R9 all clear",
        int'({feed_key, head_up, paper_end, ci_det}), 0);
  endtask

  initial begin
    rst_n = 1'b0;
    seg_cs = 1'b0; seg_addr = '0; seg_data = '0;
    keys_dn = '0; mode_on = '0;
    a_feed = 1'b0; a_head = 1'b0; a_pend = 1'b0; a_ci = 1'b0;
    for (int d = 0; d < SLOTS; d++) digit_m[d] = 8'h00;
    t_reset();
    t_scan_order();
    t_segments();
    t_single_key();
    t_hold_repress();
    t_glitch();
    t_multi();
    t_mode();
    t_aux();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule